// File: doc/BRIEF.md
# Debug Exception Priority Resolver

This block sits beside a simple processor pipeline. Each cycle it samples six event flags: an instruction breakpoint match, a prefetch abort, a data watchpoint match, a data abort, an external debug request and a pending interrupt. It then picks one outcome for the next cycle. The outcome is to continue, to take an exception, or to enter debug state. It also reports the processor mode that goes with that outcome.

Debug is handled as one more exception class, but it does not rank against aborts and interrupts in a simple way. A prefetch abort outranks a breakpoint on the same fetch, and the breakpoint is dropped with no trace. A watchpoint outranks a data abort on the same access, but the abort is kept in a sticky flag. Debug outranks a pending interrupt, but the interrupt is kept in a sticky flag and its mode becomes the debug entry mode.

While the block is in debug state it holds interrupts disabled and ignores every event input. A one-cycle exit pulse leaves debug state and clears the sticky flags.

Top module: `dbg_prio_resolver`

## Requirements
- R1: When a breakpoint match and a prefetch abort arrive together and there is no watchpoint match and no debug request, the outcome is take-exception in Abort mode. Debug state is not entered and no sticky flag is set.
- R2: Debug entry that coincides with any abort (a watchpoint together with a data abort, or a debug request together with a prefetch abort) reports Abort mode and sets the sticky abort flag `abt_seen_o`.
- R3: Debug entry with an interrupt pending and no coincident abort reports IRQ mode, or FIQ mode when the fast flag is set and `FIQ_EN` is 1. It also sets the sticky interrupt flag `int_seen_o`. If an abort also coincides, both sticky flags are set and the mode is Abort.
- R4: A debug request alone or a breakpoint alone causes debug entry and passes `cur_mode_i` through as the mode. `in_debug_o` and `int_dis_o` then both read 1 until exit.
- R5: Outside debug state, with no debug cause:
  - an abort gives take-exception in Abort mode, even when an interrupt is also pending;
  - an interrupt alone gives take-exception in IRQ or FIQ mode;
  - no event at all gives continue with `cur_mode_i` passed through.
- R6: `action_o` is one-hot, with bit 0 for continue, bit 1 for take-exception and bit 2 for enter-debug. It and `mode_o` are registered and reflect the flags sampled at the previous clock edge.
- R7: While `in_debug_o` is 1, all event inputs are ignored. The action is continue, `mode_o` follows `cur_mode_i`, and the sticky flags hold their values.
- R8: A pulse on `dbg_exit_i` clears `in_debug_o`, `int_dis_o`, `abt_seen_o` and `int_seen_o` at the next edge. Outside debug state, a debug entry in the same cycle wins over the exit pulse.
- R9: An active-low synchronous reset gives action continue, `mode_o` = `RST_MODE` (default Supervisor, 10011), and all flags clear.
- R10: Mode encodings are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bkpt_hit_i | input | 1 | Instruction breakpoint match this cycle |
| pabt_i | input | 1 | Prefetch abort this cycle |
| wpt_hit_i | input | 1 | Data watchpoint match this cycle |
| dabt_i | input | 1 | Data abort this cycle |
| dbg_req_i | input | 1 | External debug request |
| int_pend_i | input | 1 | Interrupt pending |
| int_fast_i | input | 1 | Pending interrupt is the fast class |
| cur_mode_i | input | 5 | Current processor mode |
| dbg_exit_i | input | 1 | Debug exit pulse |
| action_o | output | 3 | One-hot outcome {debug, exception, continue} |
| mode_o | output | 5 | Mode that goes with the outcome |
| in_debug_o | output | 1 | Debug state |
| int_dis_o | output | 1 | Interrupts forced disabled |
| abt_seen_o | output | 1 | Sticky: abort suppressed by debug entry |
| int_seen_o | output | 1 | Sticky: interrupt suppressed by debug entry |

## Verification
On every cycle the assertions check four things:
- the one-hot action;
- that interrupts stay disabled while in debug state;
- that debug state ignores its inputs;
- the abort rankings and the holding or clearing of the sticky flags.

Other behaviour can only be shown by the bench's scenarios. This covers mode selection across the full set of event combinations and the FIQ/IRQ choice. It also covers the sequences of entry, ignored events and exit, including an exit pulse arriving with a breakpoint, and a reset taken in the middle of debug state.

// File: rtl/dbg_prio_pkg.sv
package dbg_prio_pkg;
   localparam int MODE_W = 5;
   typedef logic [MODE_W-1:0] mode_t;

   localparam mode_t M_USR = 5'b10000;
   localparam mode_t M_FIQ = 5'b10001;
   localparam mode_t M_IRQ = 5'b10010;
   localparam mode_t M_SVC = 5'b10011;
   localparam mode_t M_ABT = 5'b10111;
   localparam mode_t M_UND = 5'b11011;
   localparam mode_t M_SYS = 5'b11111;

   typedef enum logic [2:0] {
      ACT_CONT = 3'b001,
      ACT_EXC  = 3'b010,
      ACT_DBG  = 3'b100
   } act_e;

   typedef struct packed {
      logic bkpt;
      logic pabt;
      logic wpt;
      logic dabt;
      logic req;
      logic intp;
      logic fast;
   } evt_t;
endpackage

// File: rtl/dbg_prio_decide.sv
module dbg_prio_decide
   import dbg_prio_pkg::*;
#(
   parameter bit FIQ_EN = 1'b1
) (
   input  evt_t  evt,
   input  mode_t cur_mode,
   input  logic  in_dbg,
   output act_e  act,
   output mode_t mode,
   output logic  set_abt,
   output logic  set_int
);
   logic  dbg_cause;
   logic  any_abt;
   mode_t int_mode;

   generate
      if (FIQ_EN) begin : g_fiq
         assign int_mode = evt.fast ? M_FIQ : M_IRQ;
      end else begin : g_irq_only
         assign int_mode = M_IRQ;
      end
   endgenerate

   // breakpoint survives only when its fetch did not abort
   assign dbg_cause = evt.req | evt.wpt | (evt.bkpt & ~evt.pabt);
   assign any_abt   = evt.pabt | evt.dabt;

   always_comb begin
      act     = ACT_CONT;
      mode    = cur_mode;
      set_abt = 1'b0;
      set_int = 1'b0;
      if (!in_dbg) begin
         if (dbg_cause) begin
            act     = ACT_DBG;
            set_abt = any_abt;
            set_int = evt.intp;
            if (any_abt)        mode = M_ABT;
            else if (evt.intp)  mode = int_mode;
         end else if (any_abt) begin
            act  = ACT_EXC;
            mode = M_ABT;
         end else if (evt.intp) begin
            act  = ACT_EXC;
            mode = int_mode;
         end
      end
   end
endmodule

// File: rtl/dbg_prio_state.sv
module dbg_prio_state
   import dbg_prio_pkg::*;
#(
   parameter mode_t RST_MODE = M_SVC
) (
   input  logic  clk,
   input  logic  rst_n,
   input  act_e  act,
   input  mode_t mode,
   input  logic  set_abt,
   input  logic  set_int,
   input  logic  dbg_exit,
   output act_e  act_q,
   output mode_t mode_q,
   output logic  in_dbg_q,
   output logic  abt_q,
   output logic  int_q
);
   logic enter;
   assign enter = (act == ACT_DBG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q    <= ACT_CONT;
         mode_q   <= RST_MODE;
         in_dbg_q <= 1'b0;
         abt_q    <= 1'b0;
         int_q    <= 1'b0;
      end else begin
         act_q    <= act;
         mode_q   <= mode;
         in_dbg_q <= enter   | (in_dbg_q & ~dbg_exit);
         abt_q    <= set_abt | (abt_q    & ~dbg_exit);
         int_q    <= set_int | (int_q    & ~dbg_exit);
      end
   end
endmodule

// File: rtl/dbg_prio_resolver.sv
module dbg_prio_resolver
   import dbg_prio_pkg::*;
#(
   parameter bit    FIQ_EN   = 1'b1,
   parameter mode_t RST_MODE = M_SVC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bkpt_hit_i,
   input  logic             pabt_i,
   input  logic             wpt_hit_i,
   input  logic             dabt_i,
   input  logic             dbg_req_i,
   input  logic             int_pend_i,
   input  logic             int_fast_i,
   input  logic [MODE_W-1:0] cur_mode_i,
   input  logic             dbg_exit_i,
   output logic [2:0]       action_o,
   output logic [MODE_W-1:0] mode_o,
   output logic             in_debug_o,
   output logic             int_dis_o,
   output logic             abt_seen_o,
   output logic             int_seen_o
);
   if (RST_MODE[MODE_W-1] != 1'b1) begin : g_bad_rst_mode
      $error("RST_MODE must be a valid mode encoding (top bit set)");
   end

   evt_t  evt;
   act_e  act_d, act_q;
   mode_t mode_d;
   logic  set_abt, set_int;

   assign evt = '{bkpt: bkpt_hit_i, pabt: pabt_i, wpt: wpt_hit_i,
                  dabt: dabt_i, req: dbg_req_i, intp: int_pend_i,
                  fast: int_fast_i};

   dbg_prio_decide #(.FIQ_EN(FIQ_EN)) decide_i (
      .evt      (evt),
      .cur_mode (cur_mode_i),
      .in_dbg   (in_debug_o),
      .act      (act_d),
      .mode     (mode_d),
      .set_abt  (set_abt),
      .set_int  (set_int)
   );

   dbg_prio_state #(.RST_MODE(RST_MODE)) state_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .act      (act_d),
      .mode     (mode_d),
      .set_abt  (set_abt),
      .set_int  (set_int),
      .dbg_exit (dbg_exit_i),
      .act_q    (act_q),
      .mode_q   (mode_o),
      .in_dbg_q (in_debug_o),
      .abt_q    (abt_seen_o),
      .int_q    (int_seen_o)
   );

   assign action_o  = act_q;
   assign int_dis_o = in_debug_o;
endmodule

// File: rtl/dbg_prio_chk.sv
module dbg_prio_chk
   import dbg_prio_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             bkpt_hit_i,
   input logic             pabt_i,
   input logic             wpt_hit_i,
   input logic             dabt_i,
   input logic             dbg_req_i,
   input logic             int_pend_i,
   input logic [MODE_W-1:0] cur_mode_i,
   input logic             dbg_exit_i,
   input logic [2:0]       action_o,
   input logic [MODE_W-1:0] mode_o,
   input logic             in_debug_o,
   input logic             int_dis_o,
   input logic             abt_seen_o,
   input logic             int_seen_o
);
   a_r6_action_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(action_o) == 1);

   a_r4_int_disabled_in_debug: assert property (@(posedge clk) disable iff (!rst_n)
      in_debug_o |-> int_dis_o);

   a_r1_pabt_drops_bkpt: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !in_debug_o && bkpt_hit_i && pabt_i && !wpt_hit_i && !dbg_req_i)
      |=> (action_o == 3'b010 && mode_o == M_ABT && !in_debug_o));

   a_r2_wpt_over_dabt: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !in_debug_o && wpt_hit_i && dabt_i)
      |=> (action_o == 3'b100 && mode_o == M_ABT && abt_seen_o && in_debug_o));

   a_r7_debug_ignores_events: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && in_debug_o) |=> (action_o == 3'b001 && mode_o == $past(cur_mode_i)));

   a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && abt_seen_o && !dbg_exit_i) |=> abt_seen_o);

   a_r8_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && in_debug_o && dbg_exit_i)
      |=> (!in_debug_o && !abt_seen_o && !int_seen_o));
endmodule

bind dbg_prio_resolver dbg_prio_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .bkpt_hit_i (bkpt_hit_i),
   .pabt_i     (pabt_i),
   .wpt_hit_i  (wpt_hit_i),
   .dabt_i     (dabt_i),
   .dbg_req_i  (dbg_req_i),
   .int_pend_i (int_pend_i),
   .cur_mode_i (cur_mode_i),
   .dbg_exit_i (dbg_exit_i),
   .action_o   (action_o),
   .mode_o     (mode_o),
   .in_debug_o (in_debug_o),
   .int_dis_o  (int_dis_o),
   .abt_seen_o (abt_seen_o),
   .int_seen_o (int_seen_o)
);

// File: tb/dbg_prio_resolver_tb_top.sv
module dbg_prio_resolver_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bkpt, pabt, wpt, dabt, req, intp, fast, dexit;
   logic [4:0] cur_mode;
   logic [2:0] action;
   logic [4:0] mode;
   logic       in_dbg, int_dis, abt_seen, int_seen;
   int         checks = 0;
   int         errors = 0;

   always #5 clk = ~clk;

   dbg_prio_resolver dut_i (
      .clk(clk), .rst_n(rst_n), .bkpt_hit_i(bkpt), .pabt_i(pabt),
      .wpt_hit_i(wpt), .dabt_i(dabt), .dbg_req_i(req), .int_pend_i(intp),
      .int_fast_i(fast), .cur_mode_i(cur_mode), .dbg_exit_i(dexit),
      .action_o(action), .mode_o(mode), .in_debug_o(in_dbg),
      .int_dis_o(int_dis), .abt_seen_o(abt_seen), .int_seen_o(int_seen));

   localparam logic [2:0] C = 3'b001, X = 3'b010, D = 3'b100;
   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                          SVC = 5'b10011, ABT = 5'b10111, SYS = 5'b11111;
   localparam int NV = 19;
   // {bkpt,pabt,wpt,dabt,req,int,fast}, cur_mode, exit | action, mode, {abt,int,dbg}
   localparam logic [23:0] VEC [NV] = '{
      {7'b0000000, USR, 1'b0, C, USR, 3'b000},  // 0  R5 idle
      {7'b0000010, USR, 1'b0, X, IRQ, 3'b000},  // 1  R5 irq
      {7'b0000011, USR, 1'b0, X, FIQ, 3'b000},  // 2  R5 fiq
      {7'b0100000, USR, 1'b0, X, ABT, 3'b000},  // 3  R5 pabt
      {7'b1100000, USR, 1'b0, X, ABT, 3'b000},  // 4  R1
      {7'b0001000, USR, 1'b0, X, ABT, 3'b000},  // 5  R5 dabt
      {7'b1000000, SVC, 1'b0, D, SVC, 3'b001},  // 6  R4 bkpt
      {7'b0011010, SYS, 1'b0, C, SYS, 3'b001},  // 7  R7 ignored
      {7'b0000000, USR, 1'b1, C, USR, 3'b000},  // 8  R8 exit
      {7'b0011000, USR, 1'b0, D, ABT, 3'b101},  // 9  R2
      {7'b0000110, USR, 1'b0, C, USR, 3'b101},  // 10 R7 hold
      {7'b0000000, USR, 1'b1, C, USR, 3'b000},  // 11 R8
      {7'b0000110, USR, 1'b0, D, IRQ, 3'b011},  // 12 R3
      {7'b1000000, USR, 1'b1, C, USR, 3'b000},  // 13 R8 exit with bkpt
      {7'b0011011, USR, 1'b0, D, ABT, 3'b111},  // 14 R3 both flags
      {7'b0000000, USR, 1'b1, C, USR, 3'b000},  // 15 R8
      {7'b1100010, USR, 1'b0, X, ABT, 3'b000},  // 16 R5 abort over int
      {7'b0100100, USR, 1'b0, D, ABT, 3'b101},  // 17 R2 req+pabt
      {7'b0000000, USR, 1'b1, C, USR, 3'b000}   // 18 R8
   };

   function automatic string tag_of(int i);
      case (i)
         4:                    return "R1";
         9, 17:                return "R2";
         12, 14:               return "R3";
         6:                    return "R4";
         7, 10:                return "R7";
         8, 11, 13, 15, 18:    return "R8";
         default:              return "R5";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act_v, logic [7:0] exp_v);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act_v, exp_v);
      end
   endtask

   task automatic drive(logic [6:0] ev, logic [4:0] m, logic ex);
      {bkpt, pabt, wpt, dabt, req, intp, fast} = ev;
      cur_mode = m;
      dexit = ex;
   endtask

   task automatic check_out(string tag, logic [2:0] ea, logic [4:0] em, logic [2:0] ef);
      chk(tag, "action R6", {5'b0, action}, {5'b0, ea});
      chk(tag, "mode R10", {3'b0, mode}, {3'b0, em});
      chk(tag, "flags abt/int/dbg", {5'b0, abt_seen, int_seen, in_dbg},
          {5'b0, ef});
      chk(tag, "int_dis R4", {7'b0, int_dis}, {7'b0, ef[0]});
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      drive(7'b0, USR, 1'b0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_out("R9", C, SVC, 3'b000);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][23:17], VEC[i][16:12], VEC[i][11]);
         @(negedge clk);
         check_out(tag_of(i), VEC[i][10:8], VEC[i][7:3], VEC[i][2:0]);
      end
      // R8: entry wins over a simultaneous exit when not in debug
      drive(7'b0000100, SYS, 1'b1);
      @(negedge clk);
      check_out("R8", D, SYS, 3'b001);
      // R9: reset taken in the middle of debug state
      drive(7'b0011010, USR, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      check_out("R9", C, SVC, 3'b000);
      rst_n = 1'b1;
      drive(7'b0, USR, 1'b0);
      @(negedge clk);
      check_out("R5", C, USR, 3'b000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule